// File: doc/BRIEF.md
# Stream Address Buffer Prefetch Issuer

This block converts instruction-side cache access addresses into a stream of instruction prefetch addresses. It follows a small set of active streams, each one a pointer into a circular history of compacted region records. A record names a trigger block and carries two bit vectors: one for the blocks just below the trigger, one for the blocks just above it. When an access falls inside the record that a stream points at, that stream moves forward by one history slot, and the record found at the new slot is unpacked into block addresses.

When no active stream covers the access, the block consults an external index with the access block number. An index hit opens a new stream at the slot it returns, and that record is unpacked. An index miss produces no prefetches. The unpacked addresses leave one per cycle on a valid/ready port. A new access is taken only after the previous record has been fully unpacked. The history contents come in as flat read-only buses, and the index lookup is combinational. Neither structure is part of this block.

Top module: `sab_prefetch_issuer`

## Requirements
- R1: After a synchronous active-low reset, no stream is active, `pf_valid` is 0 and `acc_ready` is 1.
- R2: An access is taken in a cycle where `acc_valid` and `acc_ready` are both 1. `acc_ready` is 1 exactly when no prefetch address is pending. An access held while the block is busy has no effect until it is taken.
- R3: Let `b` be the access block (`acc_addr >> BLK_LOG`) and `t` the record's trigger block. The access is covered when `b == t`. When `b > t`, it is covered when `d = b - t` is between 1 and `SUCC_N` and bit `d-1` of the succeeding vector is set. When `b < t`, it is covered when `d = t - b` is between 1 and `PREC_N` and bit `d-1` of the preceding vector is set. The succeeding vector is never used for the lower side.
- R4: Streams are searched from oldest to newest, and only the first covering stream is acted on. Its pointer moves to the next slot, wrapping from `HIST_N-1` to 0, and the record at the new slot is unpacked. The index result is ignored in that case.
- R5: When no stream covers the access and `idx_hit` is 1, a new stream is opened at `idx_slot` and the record at that slot is unpacked. When `idx_hit` is 0, nothing is issued and no stream is opened.
- R6: At most `STREAMS` (7) streams are held. Opening a stream while all are in use discards the oldest one.
- R7: Unpacking emits the set preceding bits from the farthest to the nearest, then the set succeeding bits from the nearest to the farthest. The trigger block itself is never emitted. A record with no bits set emits nothing.
- R8: Preceding bit `i` yields `(t - (i+1)) << BLK_LOG`. Succeeding bit `i` yields `(t + (i+1)) << BLK_LOG`. Block numbers wrap modulo `2^(ADDR_W-BLK_LOG)`.
- R9: One address is offered per cycle. While `pf_ready` is 0, `pf_valid` and `pf_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Cache access present |
| acc_addr | input | ADDR_W | Cache access byte address |
| acc_ready | output | 1 | Block can take an access |
| idx_blk | output | ADDR_W-BLK_LOG | Block number sent to the index lookup |
| idx_hit | input | 1 | Index holds an entry for `idx_blk` |
| idx_slot | input | $clog2(HIST_N) | History slot returned by the index |
| hist_trig | input | HIST_N*(ADDR_W-BLK_LOG) | Trigger block of every history slot, slot 0 in the low bits |
| hist_prec | input | HIST_N*PREC_N | Preceding-side vector of every slot |
| hist_succ | input | HIST_N*SUCC_N | Succeeding-side vector of every slot |
| pf_valid | output | 1 | Prefetch address offered |
| pf_addr | output | ADDR_W | Block-aligned prefetch address |
| pf_ready | input | 1 | Consumer takes the offered address |

## Verification
The bound checker tests the output handshake on every cycle. It confirms that an offered address stays frozen under back-pressure, that `pf_valid` rises only in the cycle after an access was taken, that `pf_valid` drops only after a take, and that two consecutive takes never repeat an address. The coverage rule and the choice of vector for each side, the oldest-first pick, the slot wrap, eviction of the oldest stream, the ignored index on a stream hit, and the exact order and values of the unpacked addresses can only be shown by the bench scenarios. These are compared cycle by cycle against a behavioural queue model.

// File: rtl/sab_pkg.sv
// Shared defaults and helpers for the stream address buffer prefetch issuer.
// Assumes history slot numbers fit in a 32-bit int.
package sab_pkg;
    localparam int SAB_ADDR_W  = 32;
    localparam int SAB_BLK_LOG = 6;
    localparam int SAB_PREC_N  = 2;
    localparam int SAB_SUCC_N  = 8;
    localparam int SAB_HIST_N  = 16;
    localparam int SAB_STREAMS = 7;

    // Next history slot in a ring of ring_n entries.
    function automatic int unsigned ring_next(int unsigned slot, int unsigned ring_n);
        return (slot == ring_n - 1) ? 0 : slot + 1;
    endfunction
endpackage

// File: rtl/sab_region_match.sv
// Region cover test: decides whether a probe block lies inside one record.
// The probe is covered when it equals the trigger block, or when it sits
// d blocks above (below) the trigger and succeeding (preceding) bit d-1
// is set. Purely combinational. Assumes PREC_N and SUCC_N >= 1.
module sab_region_match #(
    parameter int BN_W   = 26,
    parameter int PREC_N = 2,
    parameter int SUCC_N = 8
) (
    input  logic [BN_W-1:0]   probe_blk,
    input  logic [BN_W-1:0]   trig_blk,
    input  logic [PREC_N-1:0] prec_bits,
    input  logic [SUCC_N-1:0] succ_bits,
    output logic              covered
);
    logic [BN_W-1:0] up_dist;
    logic [BN_W-1:0] dn_dist;
    logic            above;
    logic            below;

    // Distances on both sides of the trigger.
    always_comb begin
        up_dist = probe_blk - trig_blk;
        dn_dist = trig_blk - probe_blk;
        above   = probe_blk > trig_blk;
        below   = probe_blk < trig_blk;
    end

    // Cover decision: exact trigger, or a set bit at distance-1 on the proper side.
    always_comb begin
        covered = (probe_blk == trig_blk);
        for (int i = 0; i < SUCC_N; i++) begin
            if (above && (up_dist == BN_W'(i + 1)) && succ_bits[i]) begin
                covered = 1'b1;
            end
        end
        for (int i = 0; i < PREC_N; i++) begin
            if (below && (dn_dist == BN_W'(i + 1)) && prec_bits[i]) begin
                covered = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sab_stream_table.sv
// Active stream table: holds up to STREAMS history pointers, oldest first.
// It tests every live pointer's record against the probe block. Among the
// covering streams it reports the oldest one, along with that stream's
// next slot. advance moves that stream forward. alloc appends a pointer and
// discards the oldest one when the table is full.
// Assumes advance and alloc are never high together.
module sab_stream_table #(
    parameter int BN_W    = 26,
    parameter int PREC_N  = 2,
    parameter int SUCC_N  = 8,
    parameter int HIST_N  = 16,
    parameter int STREAMS = 7,
    localparam int SLOT_W = $clog2(HIST_N),
    localparam int CNT_W  = $clog2(STREAMS + 1),
    localparam int SEL_W  = (STREAMS > 1) ? $clog2(STREAMS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BN_W-1:0]          probe_blk,
    input  logic [HIST_N*BN_W-1:0]   hist_trig,
    input  logic [HIST_N*PREC_N-1:0] hist_prec,
    input  logic [HIST_N*SUCC_N-1:0] hist_succ,
    input  logic                     advance,
    input  logic                     alloc,
    input  logic [SLOT_W-1:0]        alloc_slot,
    output logic                     any_hit,
    output logic [SLOT_W-1:0]        hit_next_slot
);
    logic [SLOT_W-1:0] ptr_q [STREAMS];
    logic [CNT_W-1:0]  cnt_q;
    logic [STREAMS-1:0] hit_vec;
    logic [SEL_W-1:0]  first_sel;
    logic              table_full;

    // One cover test per stream entry, each reading the record at its pointer.
    for (genvar k = 0; k < STREAMS; k++) begin : g_stream
        logic covered_k;
        sab_region_match #(
            .BN_W   (BN_W),
            .PREC_N (PREC_N),
            .SUCC_N (SUCC_N)
        ) u_match (
            .probe_blk (probe_blk),
            .trig_blk  (hist_trig[ptr_q[k]*BN_W +: BN_W]),
            .prec_bits (hist_prec[ptr_q[k]*PREC_N +: PREC_N]),
            .succ_bits (hist_succ[ptr_q[k]*SUCC_N +: SUCC_N]),
            .covered   (covered_k)
        );
        assign hit_vec[k] = covered_k && (CNT_W'(k) < cnt_q);
    end

    // Oldest covering stream wins: scan from the newest down so the lowest index is kept.
    always_comb begin
        first_sel = '0;
        any_hit   = 1'b0;
        for (int k = STREAMS - 1; k >= 0; k--) begin
            if (hit_vec[k]) begin
                first_sel = SEL_W'(k);
                any_hit   = 1'b1;
            end
        end
    end

    // Next slot of the winning stream, wrapping at the end of the history ring.
    always_comb begin
        if (ptr_q[first_sel] == SLOT_W'(HIST_N - 1)) begin
            hit_next_slot = '0;
        end else begin
            hit_next_slot = ptr_q[first_sel] + SLOT_W'(1);
        end
    end

    assign table_full = (cnt_q == CNT_W'(STREAMS));

    // Pointer storage: advance in place, or append with oldest-out when full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int k = 0; k < STREAMS; k++) begin
                ptr_q[k] <= '0;
            end
        end else if (advance) begin
            ptr_q[first_sel] <= hit_next_slot;
        end else if (alloc) begin
            if (table_full) begin
                for (int k = 0; k < STREAMS - 1; k++) begin
                    ptr_q[k] <= ptr_q[k + 1];
                end
                ptr_q[STREAMS - 1] <= alloc_slot;
            end else begin
                ptr_q[SEL_W'(cnt_q)] <= alloc_slot;
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sab_expander.sv
// Record unpacker: loads one record and serialises its set bits into
// block-aligned addresses, one per accepted output cycle. The preceding
// bits are issued farthest first, then the succeeding bits nearest first.
// Assumes load is raised only while nothing is pending.
module sab_expander #(
    parameter int BN_W    = 26,
    parameter int PREC_N  = 2,
    parameter int SUCC_N  = 8,
    parameter int BLK_LOG = 6,
    localparam int VEC_N  = PREC_N + SUCC_N,
    localparam int PICK_W = $clog2(VEC_N),
    localparam int ADDR_W = BN_W + BLK_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BN_W-1:0]   load_trig,
    input  logic [PREC_N-1:0] load_prec,
    input  logic [SUCC_N-1:0] load_succ,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    input  logic              out_ready
);
    logic [BN_W-1:0]   trig_q;
    logic [VEC_N-1:0]  mask_q;
    logic [VEC_N-1:0]  order_vec;
    logic [PICK_W-1:0] pick;
    logic [BN_W-1:0]   out_blk;

    // Issue order: slot j < PREC_N holds preceding bit PREC_N-1-j, the rest hold succeeding bits in order.
    for (genvar j = 0; j < PREC_N; j++) begin : g_prec_order
        assign order_vec[j] = load_prec[PREC_N - 1 - j];
    end
    for (genvar j = 0; j < SUCC_N; j++) begin : g_succ_order
        assign order_vec[PREC_N + j] = load_succ[j];
    end

    // Lowest pending position is issued next.
    always_comb begin
        pick = '0;
        for (int j = VEC_N - 1; j >= 0; j--) begin
            if (mask_q[j]) begin
                pick = PICK_W'(j);
            end
        end
    end

    // Block number of the picked position relative to the trigger.
    always_comb begin
        if (pick < PICK_W'(PREC_N)) begin
            out_blk = trig_q - (BN_W'(PREC_N) - BN_W'(pick));
        end else begin
            out_blk = trig_q + (BN_W'(pick) - BN_W'(PREC_N) + BN_W'(1));
        end
    end

    assign out_valid = |mask_q;
    assign out_addr  = {out_blk, {BLK_LOG{1'b0}}};

    // Pending mask: load a record, then clear one position per accepted output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
            mask_q <= '0;
        end else if (load) begin
            trig_q <= load_trig;
            mask_q <= order_vec;
        end else if (out_valid && out_ready) begin
            mask_q[pick] <= 1'b0;
        end
    end
endmodule

// File: rtl/sab_prefetch_issuer.sv
// Stream address buffer prefetch issuer (top).
// Takes one cache access at a time, when the unpacker is idle. The access
// is first tested against the active streams. A covering stream advances
// one slot and its new record is unpacked. Otherwise the external index
// is queried, and a hit opens a stream and unpacks the returned slot.
// Assumes the index lookup and the history buses are combinational views
// that stay valid in the cycle the access is taken.
module sab_prefetch_issuer #(
    parameter int ADDR_W  = sab_pkg::SAB_ADDR_W,
    parameter int BLK_LOG = sab_pkg::SAB_BLK_LOG,
    parameter int PREC_N  = sab_pkg::SAB_PREC_N,
    parameter int SUCC_N  = sab_pkg::SAB_SUCC_N,
    parameter int HIST_N  = sab_pkg::SAB_HIST_N,
    parameter int STREAMS = sab_pkg::SAB_STREAMS,
    localparam int BN_W   = ADDR_W - BLK_LOG,
    localparam int SLOT_W = $clog2(HIST_N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_valid,
    input  logic [ADDR_W-1:0]        acc_addr,
    output logic                     acc_ready,
    output logic [BN_W-1:0]          idx_blk,
    input  logic                     idx_hit,
    input  logic [SLOT_W-1:0]        idx_slot,
    input  logic [HIST_N*BN_W-1:0]   hist_trig,
    input  logic [HIST_N*PREC_N-1:0] hist_prec,
    input  logic [HIST_N*SUCC_N-1:0] hist_succ,
    output logic                     pf_valid,
    output logic [ADDR_W-1:0]        pf_addr,
    input  logic                     pf_ready
);
    logic [BN_W-1:0]   acc_blk;
    logic              unused_offset;
    logic              take;
    logic              any_hit;
    logic [SLOT_W-1:0] hit_next_slot;
    logic              advance;
    logic              alloc;
    logic [SLOT_W-1:0] sel_slot;
    logic              load;

    // Access decode: block number and the ignored byte offset.
    assign acc_blk       = acc_addr[ADDR_W-1:BLK_LOG];
    assign unused_offset = ^acc_addr[BLK_LOG-1:0];
    assign idx_blk       = acc_blk;

    // Handshake: accept only when no address is pending.
    assign acc_ready = !pf_valid;
    assign take      = acc_valid && acc_ready;

    // Action select: stream advance has priority over the index.
    assign advance  = take && any_hit;
    assign alloc    = take && !any_hit && idx_hit;
    assign sel_slot = any_hit ? hit_next_slot : idx_slot;
    assign load     = advance || alloc;

    sab_stream_table #(
        .BN_W    (BN_W),
        .PREC_N  (PREC_N),
        .SUCC_N  (SUCC_N),
        .HIST_N  (HIST_N),
        .STREAMS (STREAMS)
    ) u_table (
        .clk           (clk),
        .rst_n         (rst_n),
        .probe_blk     (acc_blk),
        .hist_trig     (hist_trig),
        .hist_prec     (hist_prec),
        .hist_succ     (hist_succ),
        .advance       (advance),
        .alloc         (alloc),
        .alloc_slot    (idx_slot),
        .any_hit       (any_hit),
        .hit_next_slot (hit_next_slot)
    );

    sab_expander #(
        .BN_W    (BN_W),
        .PREC_N  (PREC_N),
        .SUCC_N  (SUCC_N),
        .BLK_LOG (BLK_LOG)
    ) u_expand (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_trig (hist_trig[sel_slot*BN_W +: BN_W]),
        .load_prec (hist_prec[sel_slot*PREC_N +: PREC_N]),
        .load_succ (hist_succ[sel_slot*SUCC_N +: SUCC_N]),
        .out_valid (pf_valid),
        .out_addr  (pf_addr),
        .out_ready (pf_ready)
    );
endmodule

// File: rtl/sab_prefetch_issuer_chk.sv
// Protocol checker for the prefetch issuer, bound to every instance of the top.
// Observes ports only.
module sab_prefetch_issuer_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_ready,
    input logic              pf_valid,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              pf_ready
);
    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr)); // R9
    AST_START_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> $past(acc_valid && acc_ready)); // R2
    AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pf_valid) |-> $past(pf_ready)); // R9
    AST_NO_REPEAT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && pf_ready |=> !pf_valid || (pf_addr != $past(pf_addr))); // R7
endmodule

bind sab_prefetch_issuer sab_prefetch_issuer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_ready (acc_ready),
    .pf_valid  (pf_valid),
    .pf_addr   (pf_addr),
    .pf_ready  (pf_ready)
);

// File: tb/sab_prefetch_issuer_tb.sv
// Bench: behavioural queue model compared with the design on every cycle.
module sab_prefetch_issuer_tb;
    localparam int AW = 32, BL = 6, P = 2, S = 8, HN = 16, NS = 7;
    localparam int BW = AW - BL, SW = 4;

    logic clk = 0, rst_n = 0;
    logic acc_valid = 0, pf_ready = 0;
    logic [AW-1:0] acc_addr = '0;
    logic acc_ready, pf_valid, idx_hit;
    logic [AW-1:0] pf_addr;
    logic [BW-1:0] idx_blk;
    logic [SW-1:0] idx_slot;
    logic [HN*BW-1:0] hist_trig;
    logic [HN*P-1:0]  hist_prec;
    logic [HN*S-1:0]  hist_succ;

    logic [BW-1:0] h_t [HN];
    logic [P-1:0]  h_p [HN];
    logic [S-1:0]  h_s [HN];
    int ix_key [6] = '{5000, 6000, 7000, 1120, 8000, 9000};
    int ix_val [6] = '{15, 3, 2, 9, 10, 12};

    int vectors = 0, miscompares = 0, cyc = 0;
    string cur_req = "R1";
    logic [AW-1:0] exq [$];
    int sq [$];

    always #10 clk = ~clk;

    sab_prefetch_issuer u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_ready(acc_ready), .idx_blk(idx_blk), .idx_hit(idx_hit), .idx_slot(idx_slot),
        .hist_trig(hist_trig), .hist_prec(hist_prec), .hist_succ(hist_succ),
        .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready)
    );

    // History buses and index lookup seen by the design.
    always_comb begin
        for (int s = 0; s < HN; s++) begin
            hist_trig[s*BW +: BW] = h_t[s];
            hist_prec[s*P +: P]   = h_p[s];
            hist_succ[s*S +: S]   = h_s[s];
        end
        idx_hit  = 1'b0;
        idx_slot = '0;
        for (int e = 0; e < 6; e++) begin
            if (int'(idx_blk) == ix_key[e]) begin
                idx_hit  = 1'b1;
                idx_slot = SW'(ix_val[e]);
            end
        end
    end

    function automatic void model_expand(int s);
        int t = int'(h_t[s]);
        for (int i = P - 1; i >= 0; i--)
            if (h_p[s][i]) exq.push_back(AW'(t - (i + 1)) << BL);
        for (int i = 0; i < S; i++)
            if (h_s[s][i]) exq.push_back(AW'(t + i + 1) << BL);
    endfunction

    function automatic bit model_cover(int s, int b);
        int t = int'(h_t[s]);
        if (b == t) return 1;
        if (b > t) return (b - t <= S) && h_s[s][b - t - 1];
        return (t - b <= P) && h_p[s][t - b - 1];
    endfunction

    function automatic void model_take(int b);
        for (int k = 0; k < sq.size(); k++) begin
            if (model_cover(sq[k], b)) begin
                sq[k] = (sq[k] + 1) % HN;
                model_expand(sq[k]);
                return;
            end
        end
        for (int e = 0; e < 6; e++) begin
            if (ix_key[e] == b) begin
                if (sq.size() == NS) void'(sq.pop_front());
                sq.push_back(ix_val[e]);
                model_expand(ix_val[e]);
                return;
            end
        end
    endfunction

    // One cycle: compare at the falling edge, drive inputs, advance the model.
    task automatic step(input bit av, input int blk, input bit pr, output bit took);
        bit ev = exq.size() > 0;
        vectors++;
        if (pf_valid !== ev || acc_ready !== !ev || (ev && pf_addr !== exq[0])) begin
            miscompares++;
            $display("FAIL %s: pf_valid=%0b exp %0b, acc_ready=%0b exp %0b, pf_addr=%h exp %h",
                     cur_req, pf_valid, ev, acc_ready, !ev, pf_addr, ev ? exq[0] : '0);
        end
        acc_valid = av;
        acc_addr  = (AW'(blk) << BL) | AW'(blk % 64);
        pf_ready  = pr;
        took = av && !ev;
        if (ev && pr) void'(exq.pop_front());
        if (took) model_take(blk);
        @(negedge clk);
    endtask

    task automatic access(input int blk, input int bp);
        bit took = 0;
        while (!took) step(1, blk, (bp == 0) || (cyc % bp != 0), took);
    endtask

    task automatic drain(input int bp);
        bit took;
        while (exq.size() > 0) step(0, 0, (bp == 0) || (cyc % bp != 0), took);
        step(0, 0, 1, took);
        step(0, 0, 1, took);
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            miscompares++;
            $display("FAIL watchdog: cycles=%0d exp below 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        bit took;
        int unsigned lcg = 32'h1234_5678;
        for (int s = 0; s < HN; s++) begin
            h_t[s] = BW'(1000 + 40 * s);
            h_p[s] = P'(s % 4);
            h_s[s] = S'((s * 37 + 11) % 256) | S'(1);
        end
        h_p[3] = '0;
        h_s[3] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: idle after reset
        cur_req = "R1"; step(0, 0, 1, took); step(0, 0, 1, took);
        // R5 index hit opens a stream at slot 15; R7/R8 order and values
        cur_req = "R7"; access(5000, 0); drain(0);
        // R4 wrap from slot 15 to slot 0 on a succeeding-side cover
        cur_req = "R4"; access(1600 + 1, 0); drain(0);
        // R5 index miss issues nothing
        cur_req = "R5"; access(6500, 0); drain(0);
        cur_req = "R8"; access(7000, 0); drain(0);
        // R3: below by 1 uses preceding bit 0 (clear) even though succeeding bit 0 is set
        cur_req = "R3"; access(1080 - 1, 0); drain(0);
        // R3 preceding bit 1 covers; R7 the empty slot 3 then emits nothing
        cur_req = "R3"; access(1080 - 2, 0); drain(0);
        // R4 index entry for this block is ignored when a stream covers it; R9 stalls
        cur_req = "R4"; access(1120, 3); drain(2);
        cur_req = "R9"; access(1160 + 1, 2); drain(3);
        // R4 oldest of two covering streams is advanced first
        cur_req = "R4"; access(8000, 0); drain(0); access(8000, 0); drain(0);
        access(1400, 0); drain(0); access(1400, 0); drain(0);
        // R6 table holds seven: older streams are pushed out
        cur_req = "R6";
        for (int n = 0; n < 7; n++) begin access(9000, 0); drain(0); end
        access(1440, 0); drain(0);
        access(1480, 0); drain(0);
        // R2 mixed traffic with held requests and back-pressure
        cur_req = "R2";
        for (int n = 0; n < 80; n++) begin
            int blk;
            lcg = lcg * 1103515245 + 12345;
            blk = (lcg[20:18] == 0) ? ix_key[lcg[10:8] % 6] : 990 + int'(lcg[29:16] % 660);
            access(blk, 2 + int'(lcg[3:2]));
        end
        drain(0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule